// File: doc/BRIEF.md
# Reduced-Shift Partial Scan Controller

This block applies a stored test to a design in which only part of the flip-flops sit on a serial scan chain. It contains the scanned elements and the unscanned elements. For each incoming test record it shifts only the number of cycles that record asks for, then gives one functional clock to capture the response. During every shift the unscanned elements keep their values.

Records arrive on a valid/ready stream. Each record carries:
- the target values for the chain,
- a shift length,
- a capture flag,
- a last flag,
- a final unload length.

Every bit that leaves the scan output is returned on a response stream. That stream can stall the shift. The block counts the shift and capture clocks of a test session. Beside that count it reports what the same number of vectors would cost on a full-length shift of the same chain.

A single scan-enable output tells the rest of the chip whether the block is in normal (capture) mode or in shift mode. The direction of the chain over the element indices is a parameter (`INPUT_AT_MSB`) fixed at elaboration. This lets elements that are often controlled sit near the scan input and elements that are often observed sit near the scan output.

Top module: `psc_top`

## Requirements
- R1: After reset, the outputs are as follows: `rec_ready`=1, `resp_valid`=0, `scan_en`=0, `scan_clk_en`=1, `hold_clk_en`=1, `done`=0, `cycle_count`=0, and `scan_q` and `hold_q` are all zero.
- R2: A record is taken on a clock edge where `rec_valid` and `rec_ready` are both 1. `rec_ready` is 1 only while idle or while waiting between records of a session, and it is never 1 while `resp_valid` is 1.
- R3: The chain shifts as follows (with the default `INPUT_AT_MSB`=0, element i sits at chain position i, and position 0 is next to the scan input):
  - Each shift clock moves every position one step toward position N_SCAN-1.
  - `scan_in` enters position 0.
  - The bit that was at position N_SCAN-1 is presented on `resp_bit`.
  - For a shift length S, the controller feeds `rec_bits[S-1]` first and `rec_bits[0]` last. Afterwards position j<S holds `rec_bits[j]` and position j≥S holds what position j-S held.
- R4: A shift length of 0 goes straight to capture or to the end of the record. Shift and unload lengths above N_SCAN are treated as N_SCAN.
- R5: A record with `rec_capture`=1 gets exactly one functional clock after its shifts. During that clock:
  - `scan_en` is 0 and both clock enables are 1.
  - Element i of the chain loads `func_scan_d[i]`.
  - The unscanned elements load `func_hold_d`.
  
  With `rec_capture`=0 there is no functional clock and neither group of elements loads functional data.
- R6: Whenever `scan_en` is 1, `hold_clk_en` is 0 and `hold_q` does not change.
- R7: `resp_valid` is 1 in every shift cycle. A shift happens only on an edge where `resp_ready` is 1; otherwise the chain does not change.
- R8: After the record flagged last, the controller performs the requested number of unload shifts with `scan_in`=0. It then raises `done` and returns to normal mode with `scan_en`=0 and both clock enables 1.
- R9: `cycle_count` counts every shift clock and every capture clock since the first record of the current session. It restarts at the first record taken while idle.
- R10: `full_scan_cycles` equals V×(N_SCAN+1)+N_SCAN, where V is the number of records taken in the current session.
- R11: While idle, every clock loads `func_scan_d` into the chain and `func_hold_d` into the unscanned elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid | input | 1 | Record offered |
| rec_ready | output | 1 | Record can be taken |
| rec_bits | input | N_SCAN | Target chain values, bit j for position j |
| rec_shift | input | $clog2(N_SCAN+1) | Shift length before capture |
| rec_capture | input | 1 | Apply one functional clock after the shifts |
| rec_last | input | 1 | Final record of the session |
| rec_unload | input | $clog2(N_SCAN+1) | Unload length after a last record |
| resp_valid | output | 1 | Response bit offered (shift cycle) |
| resp_ready | input | 1 | Response bit taken; gates the shift |
| resp_bit | output | 1 | Bit leaving the scan output |
| func_scan_d | input | N_SCAN | Functional next values of the scanned elements |
| func_hold_d | input | N_HOLD | Functional next values of the unscanned elements |
| scan_q | output | N_SCAN | Scanned element values, by element index |
| hold_q | output | N_HOLD | Unscanned element values |
| scan_en | output | 1 | 1 = shift mode, 0 = normal mode |
| scan_clk_en | output | 1 | Clock enable of the scanned elements |
| hold_clk_en | output | 1 | Clock enable of the unscanned elements |
| scan_in | output | 1 | Serial bit entering the chain |
| done | output | 1 | Session finished |
| cycle_count | output | CYC_W | Shift plus capture clocks of the session |
| full_scan_cycles | output | CYC_W | Full-length shift cost of the same vector count |

## Verification
Timing of the responses:
- A response bit is offered in the cycle before the edge that shifts it out. The bench therefore samples `resp_bit` at the falling edge where it raises `resp_ready`, and counts the bit as taken only then.
- Chain contents, unscanned values, `done`, `cycle_count` and `full_scan_cycles` are compared at the first falling edge where `rec_ready` is 1 again. That is one edge after the last shift, capture or unload clock, and before any idle clock could load functional data.
- The normal-mode load while idle is checked one falling edge after the functional inputs change.
- While shifting, the unscanned values are compared at every falling edge against the value before capture or after capture.

// File: rtl/psc_pkg.sv
package psc_pkg;
    typedef enum logic [2:0] {
        PS_IDLE    = 3'd0,
        PS_SHIFT   = 3'd1,
        PS_CAPTURE = 3'd2,
        PS_WAIT    = 3'd3,
        PS_UNLOAD  = 3'd4
    } psc_state_e;
endpackage

// File: rtl/psc_chain.sv
module psc_chain #(
    parameter int unsigned N_SCAN       = 4,
    parameter bit          INPUT_AT_MSB = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              load_en,
    input  logic              scan_in,
    input  logic [N_SCAN-1:0] func_d,
    output logic [N_SCAN-1:0] elem_q,
    output logic              scan_out
);
    logic [N_SCAN-1:0] pos_d;
    logic [N_SCAN-1:0] pos_q;
    logic [N_SCAN-1:0] shift_src;

    for (genvar p = 0; p < N_SCAN; p++) begin : g_pos
        localparam int unsigned ELEM = INPUT_AT_MSB ? (N_SCAN - 1 - p) : p;
        if (p == 0) begin : g_head
            assign shift_src[p] = scan_in;
        end else begin : g_body
            assign shift_src[p] = pos_q[p-1];
        end
        assign pos_d[p]     = shift_en ? shift_src[p] :
                              load_en  ? func_d[ELEM] : pos_q[p];
        assign elem_q[ELEM] = pos_q[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign scan_out = pos_q[N_SCAN-1];
endmodule

// File: rtl/psc_hold.sv
module psc_hold #(
    parameter int unsigned N_HOLD = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [N_HOLD-1:0] d,
    output logic [N_HOLD-1:0] q
);
    logic [N_HOLD-1:0] q_d;
    logic [N_HOLD-1:0] q_q;

    always_comb q_d = en ? d : q_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/psc_seq.sv
module psc_seq
    import psc_pkg::*;
#(
    parameter int unsigned N_SCAN = 4,
    parameter int unsigned CYC_W  = 16,
    localparam int unsigned CW    = $clog2(N_SCAN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    output logic              rec_ready,
    input  logic [N_SCAN-1:0] rec_bits,
    input  logic [CW-1:0]     rec_shift,
    input  logic              rec_capture,
    input  logic              rec_last,
    input  logic [CW-1:0]     rec_unload,
    input  logic              resp_ready,
    output logic              resp_valid,
    output logic              scan_in,
    output logic              scan_en,
    output logic              shift_fire,
    output logic              load_func,
    output logic              done,
    output logic [CYC_W-1:0]  cycle_count,
    output logic [CYC_W-1:0]  vec_count
);
    typedef struct packed {
        psc_state_e        st;
        logic [CW-1:0]     remain;
        logic [N_SCAN-1:0] bits;
        logic              cap;
        logic              last;
        logic [CW-1:0]     unload;
        logic [CYC_W-1:0]  cyc;
        logic [CYC_W-1:0]  vec;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;
    logic accept, fire, after_shift, finish;

    function automatic logic [CW-1:0] clamp_len(input logic [CW-1:0] v);
        return (v > CW'(N_SCAN)) ? CW'(N_SCAN) : v;
    endfunction

    always_comb begin
        s_d         = s_q;
        after_shift = 1'b0;
        finish      = 1'b0;
        rec_ready   = (s_q.st == PS_IDLE) || (s_q.st == PS_WAIT);
        resp_valid  = (s_q.st == PS_SHIFT) || (s_q.st == PS_UNLOAD);
        accept      = rec_valid && rec_ready;
        fire        = resp_valid && resp_ready;

        case (s_q.st)
            PS_IDLE, PS_WAIT: begin
                if (accept) begin
                    s_d.bits   = rec_bits;
                    s_d.cap    = rec_capture;
                    s_d.last   = rec_last;
                    s_d.unload = clamp_len(rec_unload);
                    s_d.remain = clamp_len(rec_shift);
                    if (s_q.st == PS_IDLE) begin
                        s_d.vec  = CYC_W'(1);
                        s_d.cyc  = '0;
                        s_d.done = 1'b0;
                    end else begin
                        s_d.vec = s_q.vec + 1'b1;
                    end
                    if (s_d.remain != '0) s_d.st = PS_SHIFT;
                    else                  after_shift = 1'b1;
                end
            end
            PS_SHIFT: begin
                if (fire) begin
                    s_d.remain = s_q.remain - 1'b1;
                    s_d.cyc    = s_q.cyc + 1'b1;
                    if (s_q.remain == CW'(1)) after_shift = 1'b1;
                end
            end
            PS_CAPTURE: begin
                s_d.cyc = s_q.cyc + 1'b1;
                finish  = 1'b1;
            end
            PS_UNLOAD: begin
                if (fire) begin
                    s_d.remain = s_q.remain - 1'b1;
                    s_d.cyc    = s_q.cyc + 1'b1;
                    if (s_q.remain == CW'(1)) begin
                        s_d.st   = PS_IDLE;
                        s_d.done = 1'b1;
                    end
                end
            end
            default: s_d.st = PS_IDLE;
        endcase

        if (after_shift) begin
            if (s_d.cap) s_d.st = PS_CAPTURE;
            else         finish = 1'b1;
        end

        if (finish) begin
            if (s_d.last) begin
                if (s_d.unload != '0) begin
                    s_d.st     = PS_UNLOAD;
                    s_d.remain = s_d.unload;
                end else begin
                    s_d.st   = PS_IDLE;
                    s_d.done = 1'b1;
                end
            end else begin
                s_d.st = PS_WAIT;
            end
        end

        scan_en     = (s_q.st == PS_SHIFT) || (s_q.st == PS_UNLOAD) || (s_q.st == PS_WAIT);
        shift_fire  = fire;
        load_func   = (s_q.st == PS_IDLE) || (s_q.st == PS_CAPTURE);
        scan_in     = (s_q.st == PS_SHIFT) ? s_q.bits[s_q.remain - 1'b1] : 1'b0;
        done        = s_q.done;
        cycle_count = s_q.cyc;
        vec_count   = s_q.vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= PS_IDLE;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/psc_top.sv
module psc_top #(
    parameter int unsigned N_SCAN       = 4,
    parameter int unsigned N_HOLD       = 3,
    parameter int unsigned CYC_W        = 16,
    parameter bit          INPUT_AT_MSB = 1'b0,
    localparam int unsigned CW          = $clog2(N_SCAN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    output logic              rec_ready,
    input  logic [N_SCAN-1:0] rec_bits,
    input  logic [CW-1:0]     rec_shift,
    input  logic              rec_capture,
    input  logic              rec_last,
    input  logic [CW-1:0]     rec_unload,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic              resp_bit,
    input  logic [N_SCAN-1:0] func_scan_d,
    input  logic [N_HOLD-1:0] func_hold_d,
    output logic [N_SCAN-1:0] scan_q,
    output logic [N_HOLD-1:0] hold_q,
    output logic              scan_en,
    output logic              scan_clk_en,
    output logic              hold_clk_en,
    output logic              scan_in,
    output logic              done,
    output logic [CYC_W-1:0]  cycle_count,
    output logic [CYC_W-1:0]  full_scan_cycles
);
    logic             shift_fire;
    logic             load_func;
    logic [CYC_W-1:0] vec_count;

    psc_seq #(.N_SCAN(N_SCAN), .CYC_W(CYC_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rec_valid   (rec_valid),
        .rec_ready   (rec_ready),
        .rec_bits    (rec_bits),
        .rec_shift   (rec_shift),
        .rec_capture (rec_capture),
        .rec_last    (rec_last),
        .rec_unload  (rec_unload),
        .resp_ready  (resp_ready),
        .resp_valid  (resp_valid),
        .scan_in     (scan_in),
        .scan_en     (scan_en),
        .shift_fire  (shift_fire),
        .load_func   (load_func),
        .done        (done),
        .cycle_count (cycle_count),
        .vec_count   (vec_count)
    );

    psc_chain #(.N_SCAN(N_SCAN), .INPUT_AT_MSB(INPUT_AT_MSB)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_fire),
        .load_en  (load_func),
        .scan_in  (scan_in),
        .func_d   (func_scan_d),
        .elem_q   (scan_q),
        .scan_out (resp_bit)
    );

    psc_hold #(.N_HOLD(N_HOLD)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (load_func),
        .d     (func_hold_d),
        .q     (hold_q)
    );

    assign scan_clk_en      = shift_fire | load_func;
    assign hold_clk_en      = load_func;
    assign full_scan_cycles = vec_count * CYC_W'(N_SCAN + 1) + CYC_W'(N_SCAN);
endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
    parameter int unsigned N_SCAN = 4,
    parameter int unsigned N_HOLD = 3,
    parameter int unsigned CYC_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rec_ready,
    input logic              resp_valid,
    input logic              resp_ready,
    input logic [N_SCAN-1:0] scan_q,
    input logic [N_HOLD-1:0] hold_q,
    input logic              scan_en,
    input logic              scan_clk_en,
    input logic              hold_clk_en,
    input logic              done,
    input logic [CYC_W-1:0]  cycle_count
);
    a_r6_hold_off_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> !hold_clk_en);

    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_clk_en |=> $stable(hold_q));

    a_r7_stall_keeps_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> $stable(scan_q));

    a_r9_count_per_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_ready) |=> (cycle_count == CYC_W'($past(cycle_count) + 1'b1)));

    a_r8_done_normal_mode: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!scan_en && scan_clk_en && hold_clk_en));

    a_r2_ready_not_shifting: assert property (@(posedge clk) disable iff (!rst_n)
        rec_ready |-> !resp_valid);
endmodule

bind psc_top psc_checker #(.N_SCAN(N_SCAN), .N_HOLD(N_HOLD), .CYC_W(CYC_W)) u_psc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .rec_ready   (rec_ready),
    .resp_valid  (resp_valid),
    .resp_ready  (resp_ready),
    .scan_q      (scan_q),
    .hold_q      (hold_q),
    .scan_en     (scan_en),
    .scan_clk_en (scan_clk_en),
    .hold_clk_en (hold_clk_en),
    .done        (done),
    .cycle_count (cycle_count)
);

// File: tb/test_psc_top.sv
module test_psc_top;
    localparam int N  = 4;
    localparam int H  = 3;
    localparam int CW = 3;
    localparam int YW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rec_valid = 1'b0, rec_ready;
    logic [N-1:0] rec_bits = '0;
    logic [CW-1:0] rec_shift = '0, rec_unload = '0;
    logic rec_capture = 1'b0, rec_last = 1'b0;
    logic resp_valid, resp_ready = 1'b0, resp_bit;
    logic [N-1:0] func_scan_d = '0, scan_q;
    logic [H-1:0] func_hold_d = '0, hold_q;
    logic scan_en, scan_clk_en, hold_clk_en, scan_in, done;
    logic [YW-1:0] cycle_count, full_scan_cycles;

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;

    logic [N-1:0] m_pos;
    logic [H-1:0] m_hold;
    int sess_cyc = 0, sess_vec = 0;
    bit in_session = 1'b0;
    bit exp_q[$];
    bit got_q[$];

    always #10 clk = ~clk;

    psc_top i_psc_top (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_bits(rec_bits), .rec_shift(rec_shift), .rec_capture(rec_capture),
        .rec_last(rec_last), .rec_unload(rec_unload), .resp_valid(resp_valid),
        .resp_ready(resp_ready), .resp_bit(resp_bit), .func_scan_d(func_scan_d),
        .func_hold_d(func_hold_d), .scan_q(scan_q), .hold_q(hold_q), .scan_en(scan_en),
        .scan_clk_en(scan_clk_en), .hold_clk_en(hold_clk_en), .scan_in(scan_in),
        .done(done), .cycle_count(cycle_count), .full_scan_cycles(full_scan_cycles)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int clamp_len(input int v);
        return (v > N) ? N : v;
    endfunction

    function automatic logic [N-1:0] shift_model(input logic [N-1:0] pos, input logic [N-1:0] bits, input int s);
        logic [N-1:0] r;
        for (int j = 0; j < N; j++) r[j] = (j < s) ? bits[j] : pos[j - s];
        return r;
    endfunction

    task automatic send_record(input logic [N-1:0] bits, input int s, input bit cap,
                               input bit last, input int u);
        int sl, ul;
        logic [H-1:0] hold_before, hold_after;
        bit seen_cap;
        while (!rec_ready) @(negedge clk);
        if (!in_session) begin
            m_pos = func_scan_d;
            m_hold = func_hold_d;
            sess_cyc = 0;
            sess_vec = 0;
            in_session = 1'b1;
        end
        sl = clamp_len(s);
        ul = clamp_len(u);
        exp_q.delete();
        got_q.delete();
        for (int k = 0; k < sl; k++) exp_q.push_back(m_pos[N-1-k]);
        m_pos = shift_model(m_pos, bits, sl);
        if (cap) m_pos = func_scan_d;
        hold_before = m_hold;
        hold_after = cap ? func_hold_d : m_hold;
        if (last) begin
            for (int k = 0; k < ul; k++) exp_q.push_back(m_pos[N-1-k]);
            m_pos = shift_model(m_pos, '0, ul);
        end
        sess_cyc += sl + int'(cap) + (last ? ul : 0);
        sess_vec++;
        rec_bits = bits;
        rec_shift = CW'(s);
        rec_capture = cap;
        rec_last = last;
        rec_unload = CW'(u);
        rec_valid = 1'b1;
        @(negedge clk);
        rec_valid = 1'b0;
        seen_cap = 1'b0;
        while (!rec_ready) begin
            resp_ready = ($urandom_range(0, 3) != 0);
            if (resp_valid && resp_ready) got_q.push_back(resp_bit);
            if (scan_en) check("R6 unscanned held during shift", hold_q, seen_cap ? hold_after : hold_before);
            else begin
                seen_cap = 1'b1;
                check("R5 capture enables", {scan_clk_en, hold_clk_en}, 2'b11);
            end
            @(negedge clk);
        end
        check("R7 response bit count", got_q.size(), exp_q.size());
        for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
            check("R3 response bit order", got_q[k], exp_q[k]);
        check("R3 chain contents", scan_q, m_pos);
        check("R5 unscanned after record", hold_q, hold_after);
        m_hold = hold_after;
        if (last) begin
            check("R8 done", done, 1'b1);
            check("R8 normal mode", {scan_en, scan_clk_en, hold_clk_en}, 3'b011);
            check("R9 cycle count", cycle_count, sess_cyc);
            check("R10 full-scan figure", full_scan_cycles, sess_vec * (N + 1) + N);
            in_session = 1'b0;
            func_scan_d = N'($urandom);
            func_hold_d = H'($urandom);
            @(negedge clk);
            check("R11 idle load scanned", scan_q, func_scan_d);
            check("R11 idle load unscanned", hold_q, func_hold_d);
        end else begin
            check("R2 ready between records", {rec_ready, done, scan_en}, 3'b101);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog (R2) actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset ready", {rec_ready, resp_valid, scan_en, done}, 4'b1000);
        check("R1 reset enables", {scan_clk_en, hold_clk_en}, 2'b11);
        check("R1 reset count", cycle_count, 0);
        check("R1 reset state", {scan_q, hold_q}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: three vectors with lengths 2,1,2 and unload 1 -> 9 clocks
        func_scan_d = 4'b1010; func_hold_d = 3'b101;
        send_record(4'b0011, 2, 1'b1, 1'b0, 0);
        func_scan_d = 4'b0110; func_hold_d = 3'b010;
        send_record(4'b0001, 1, 1'b1, 1'b0, 0);
        func_scan_d = 4'b1100; func_hold_d = 3'b111;
        send_record(4'b0010, 2, 1'b1, 1'b1, 1);
        check("R9 example total 9", cycle_count, 9);
        check("R10 example full 19", full_scan_cycles, 19);

        // R4: zero shift, capture only
        send_record(4'b1111, 0, 1'b1, 1'b1, 0);
        check("R4 zero shift count", cycle_count, 1);
        // R4 clamp, R5 no capture
        send_record(4'b1001, 7, 1'b0, 1'b0, 0);
        send_record(4'b0110, 0, 1'b0, 1'b1, 7);
        check("R4 clamped length count", cycle_count, 8);

        for (int sess = 0; sess < 60; sess++) begin
            int nrec;
            nrec = $urandom_range(1, 4);
            for (int r = 0; r < nrec; r++) begin
                func_scan_d = N'($urandom);
                func_hold_d = H'($urandom);
                send_record(N'($urandom), $urandom_range(0, N), 1'($urandom),
                            (r == nrec - 1), $urandom_range(0, N));
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule